// File: doc/BRIEF.md
# SPI-to-NAND Bridge Command Engine

This block is a serial slave placed between a host processor and a raw 8-bit NAND flash device. The host selects the block with an active-low chip select and sends one opcode byte. Depending on that opcode, the block does one of three things. It can load a small configuration register that drives the NAND CE#, CLE and ALE lines plus a fan enable and four active-low LEDs. It can push bytes onto the NAND data bus with write strobes. It can fetch bytes from the NAND with read strobes and return them to the host over MISO.

All serial inputs are oversampled by the block clock through a synchronizer, so SCK is never used as a clock. Writes to the NAND use a dual-line format: two bits move per SCK rising edge, one on the primary data input and one on the secondary input. Everything else uses one line. A data byte in a write transaction is committed to the NAND one byte late, at the start of the following byte. The host therefore closes every write burst with one extra trailing byte.

Top module: `spi_nand_bridge`

## Requirements
- R1: After reset the configuration register holds 0x8F: nand_ce_n=1, nand_cle=0, nand_ale=0, fan_en=0, led_n=4'hF. Also after reset nand_we_n=1, nand_re_n=1, nand_io_oe=0 and spi_miso=0.
- R2: After opcode 0x09, every complete byte that follows is loaded into the configuration register. Bytes are sent single-line, MSB first, and sampled on SCK rising edges. The bit positions are: bit7 drives nand_ce_n, bit6 drives nand_cle, bit5 drives nand_ale, bit4 drives fan_en, and bits3..0 drive led_n[3:0].
- R3: After opcode 0x08, data bytes are sent dual-line at four SCK rising edges per byte. At each edge, spi_mosi carries the higher bit of the pair and spi_mosi2 carries the lower bit, in the order bits 7/6, 5/4, 3/2, 1/0.
- R4: A received write byte is placed on nand_io_out with one nand_we_n low pulse when the first SCK rising edge of the next byte arrives. The last byte of a transaction that has no following edge is never written.
- R5: nand_io_oe is high whenever nand_we_n is low, and is low whenever nand_re_n is low and at every point of a read transaction.
- R6: After opcode 0x0A, one idle byte follows. A nand_re_n pulse then fetches nand_io_in before each output byte, and that byte is returned on spi_miso MSB first, valid at each SCK rising edge.
- R7: After opcode 0x0B, four idle bytes follow before the first nand_re_n pulse. No read strobe occurs during the idle bytes.
- R8: In a read phase, exactly one nand_re_n pulse occurs per byte boundary, and nand_we_n and nand_re_n are never low together.
- R9: Raising spi_cs_n aborts any phase, discards a partial byte and any pending write byte, and returns the parser to waiting for an opcode. The configuration register keeps its value.
- R10: Any other opcode is ignored until spi_cs_n rises. Following bytes in that transaction cause no strobe and no configuration change.
- R11: spi_miso is low outside the read data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host (idle low) |
| spi_cs_n | input | 1 | Active-low transaction select |
| spi_mosi | input | 1 | Primary serial data input |
| spi_mosi2 | input | 1 | Secondary data input, lower bit of a pair in dual-line mode |
| spi_miso | output | 1 | Serial data returned to the host |
| nand_io_in | input | 8 | NAND data bus, input side |
| nand_io_out | output | 8 | NAND data bus, output side |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| nand_ce_n | output | 1 | NAND chip enable, active low |
| nand_cle | output | 1 | NAND command latch enable |
| nand_ale | output | 1 | NAND address latch enable |
| nand_we_n | output | 1 | NAND write strobe, active low |
| nand_re_n | output | 1 | NAND read strobe, active low |
| fan_en | output | 1 | Fan enable |
| led_n | output | 4 | Four LED drives, active low |

## Verification
With the default two synchronizer stages, an SCK rising edge is seen as a pulse two clocks after it changes. A completed byte is flagged one clock later, and configuration outputs settle one clock after that, about four clocks after the edge. Write and read strobes start in the same cycle as the byte-boundary flag and last two low clocks plus one hold clock. Read data therefore reaches spi_miso about seven clocks after the last edge of the preceding byte. The bench holds each SCK level for eight clocks. It checks configuration outputs and strobe counts only after the closing half period, and samples spi_miso just before it raises SCK, so every result is already settled when it is read.

// File: rtl/snb_pkg.sv
package snb_pkg;
   localparam int BYTE_W = 8;

   localparam logic [BYTE_W-1:0] OPC_WRITE  = 8'h08;
   localparam logic [BYTE_W-1:0] OPC_CONFIG = 8'h09;
   localparam logic [BYTE_W-1:0] OPC_READ   = 8'h0A;
   localparam logic [BYTE_W-1:0] OPC_FAST   = 8'h0B;

   typedef enum logic [2:0] {
      PH_OPCODE,
      PH_WRITE,
      PH_CONFIG,
      PH_IDLE,
      PH_READ,
      PH_IGNORE
   } phase_t;

   // bit order is decoded by the NAND pins and fan/LED drivers
   typedef struct packed {
      logic       ce_n;
      logic       cle;
      logic       ale;
      logic       fan;
      logic [3:0] led_n;
   } cfg_t;
endpackage

// File: rtl/snb_sync.sv
module snb_sync #(
   parameter int              STAGES  = 2,
   parameter int              W       = 4,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_out
);
   if (STAGES < 1) begin : g_bad
      $error("snb_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic [W-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg <= RST_VAL;
         else        stg <= d_in;
      end
      assign d_out = stg;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg <= {STAGES{RST_VAL}};
         else        stg <= {stg[STAGES-2:0], d_in};
      end
      assign d_out = stg[STAGES-1];
   end
endmodule

// File: rtl/snb_shifter.sv
module snb_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         rise,
   input  logic         dual,
   input  logic         d_hi,
   input  logic         d_lo,
   output logic         first_rise,
   output logic         mid_byte,
   output logic         byte_done,
   output logic [W-1:0] byte_val
);
   localparam int           CW   = $clog2(W) + 1;
   localparam logic [CW-1:0] FULL = CW'(W);

   if (W < 2 || (W % 2) != 0) begin : g_bad
      $error("snb_shifter: W must be even and at least 2");
   end

   logic [CW-1:0] cnt, cnt_nx;
   logic [W-1:0]  acc, acc_nx;

   always_comb begin
      cnt_nx     = cnt + (dual ? CW'(2) : CW'(1));
      acc_nx     = dual ? {acc[W-3:0], d_hi, d_lo} : {acc[W-2:0], d_hi};
      first_rise = en && rise && (cnt == '0);
      mid_byte   = (cnt != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         acc       <= '0;
         byte_done <= 1'b0;
         byte_val  <= '0;
      end else if (!en) begin
         cnt       <= '0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (rise) begin
            if (cnt_nx >= FULL) begin
               cnt       <= '0;
               byte_val  <= acc_nx;
               byte_done <= 1'b1;
            end else begin
               cnt <= cnt_nx;
               acc <= acc_nx;
            end
         end
      end
   end

   // deselect wipes a partial byte
   assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0 && !byte_done));

   // a byte completes only on the cycle after a sampled edge
   assert_done_after_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |-> $past(rise));
endmodule

// File: rtl/snb_strobe.sv
module snb_strobe #(
   parameter int LOW_CYC  = 2,
   parameter int HOLD_CYC = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic strobe_n,
   output logic busy,
   output logic last_low
);
   localparam int            TOT    = LOW_CYC + HOLD_CYC;
   localparam int            CW     = $clog2(TOT + 1);
   localparam logic [CW-1:0] TOT_V  = CW'(TOT);
   localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);
   localparam logic [CW-1:0] LAST_V = CW'(HOLD_CYC + 1);

   if (LOW_CYC < 1 || HOLD_CYC < 0) begin : g_bad
      $error("snb_strobe: LOW_CYC must be >= 1 and HOLD_CYC >= 0");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (start && cnt == '0)  cnt <= TOT_V;
      else if (cnt != '0)           cnt <= cnt - CW'(1);
   end

   assign busy     = (cnt != '0);
   assign strobe_n = !(cnt > HOLD_V);
   assign last_low = (cnt == LAST_V);

   assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

   if (LOW_CYC > 1) begin : g_width_chk
      assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(strobe_n) |=> !strobe_n);
   end
endmodule

// File: rtl/spi_nand_bridge.sv
module spi_nand_bridge
   import snb_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         WE_LOW      = 2,
   parameter int         RE_LOW      = 2,
   parameter int         HOLD_CYC    = 1,
   parameter int         SLOW_IDLE   = 1,
   parameter int         FAST_IDLE   = 4,
   parameter logic [7:0] CFG_RESET   = 8'h8F
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       spi_sck,
   input  logic       spi_cs_n,
   input  logic       spi_mosi,
   input  logic       spi_mosi2,
   output logic       spi_miso,
   input  logic [7:0] nand_io_in,
   output logic [7:0] nand_io_out,
   output logic       nand_io_oe,
   output logic       nand_ce_n,
   output logic       nand_cle,
   output logic       nand_ale,
   output logic       nand_we_n,
   output logic       nand_re_n,
   output logic       fan_en,
   output logic [3:0] led_n
);
   localparam int            MAX_IDLE = (FAST_IDLE > SLOW_IDLE) ? FAST_IDLE : SLOW_IDLE;
   localparam int            IW       = $clog2(MAX_IDLE + 1);
   localparam logic [IW-1:0] IDLE_ONE = IW'(1);

   if (SLOW_IDLE < 1 || FAST_IDLE < 1) begin : g_bad
      $error("spi_nand_bridge: idle byte counts must be at least 1");
   end

   // ---------------- serial pin capture ----------------
   logic [3:0] pins_s;
   logic       sck_s, csn_s, d_hi, d_lo, sck_prev;
   logic       cs_act, rise, fall;

   snb_sync #(.STAGES(SYNC_STAGES), .W(4), .RST_VAL(4'b0100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({spi_sck, spi_cs_n, spi_mosi, spi_mosi2}),
      .d_out (pins_s)
   );

   assign {sck_s, csn_s, d_hi, d_lo} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= sck_s;
   end

   assign cs_act = !csn_s;
   assign rise   = sck_s && !sck_prev;
   assign fall   = !sck_s && sck_prev;

   // ---------------- byte assembly ----------------
   phase_t        phase;
   logic          first_rise, mid_byte, byte_done;
   logic [BYTE_W-1:0] byte_val;

   snb_shifter #(.W(BYTE_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (cs_act),
      .rise       (rise),
      .dual       (phase == PH_WRITE),
      .d_hi       (d_hi),
      .d_lo       (d_lo),
      .first_rise (first_rise),
      .mid_byte   (mid_byte),
      .byte_done  (byte_done),
      .byte_val   (byte_val)
   );

   // ---------------- strobes ----------------
   logic       pend_v;
   logic [IW-1:0] idle_left;
   logic       we_start, re_start;
   logic       we_busy, we_last, re_busy, re_last;

   assign we_start = cs_act && first_rise && (phase == PH_WRITE) && pend_v;
   assign re_start = cs_act && byte_done &&
                     ((phase == PH_READ) || (phase == PH_IDLE && idle_left == IDLE_ONE));

   snb_strobe #(.LOW_CYC(WE_LOW), .HOLD_CYC(HOLD_CYC)) u_we (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (we_start),
      .strobe_n (nand_we_n),
      .busy     (we_busy),
      .last_low (we_last)
   );

   snb_strobe #(.LOW_CYC(RE_LOW), .HOLD_CYC(HOLD_CYC)) u_re (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (re_start),
      .strobe_n (nand_re_n),
      .busy     (re_busy),
      .last_low (re_last)
   );

   // ---------------- command parser ----------------
   cfg_t              cfg_q;
   logic [BYTE_W-1:0] pend, wdata, tx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_OPCODE;
         cfg_q     <= cfg_t'(CFG_RESET);
         pend      <= '0;
         pend_v    <= 1'b0;
         wdata     <= '0;
         idle_left <= '0;
      end else if (!cs_act) begin
         phase  <= PH_OPCODE;
         pend_v <= 1'b0;
      end else begin
         if (we_start) begin
            wdata  <= pend;
            pend_v <= 1'b0;
         end
         if (byte_done) begin
            unique case (phase)
               PH_OPCODE: begin
                  if (byte_val == OPC_WRITE)       phase <= PH_WRITE;
                  else if (byte_val == OPC_CONFIG) phase <= PH_CONFIG;
                  else if (byte_val == OPC_READ) begin
                     phase     <= PH_IDLE;
                     idle_left <= IW'(SLOW_IDLE);
                  end else if (byte_val == OPC_FAST) begin
                     phase     <= PH_IDLE;
                     idle_left <= IW'(FAST_IDLE);
                  end else                         phase <= PH_IGNORE;
               end
               PH_WRITE: begin
                  pend   <= byte_val;
                  pend_v <= 1'b1;
               end
               PH_CONFIG: cfg_q <= cfg_t'(byte_val);
               PH_IDLE: begin
                  idle_left <= idle_left - IW'(1);
                  if (idle_left == IDLE_ONE) phase <= PH_READ;
               end
               default: ;
            endcase
         end
      end
   end

   // read shift register: loaded at end of RE# low, shifted on SCK fall mid-byte
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    tx <= '0;
      else if (re_last)                              tx <= nand_io_in;
      else if (fall && mid_byte && phase == PH_READ) tx <= {tx[BYTE_W-2:0], 1'b0};
   end

   assign spi_miso    = cs_act && (phase == PH_READ) && tx[BYTE_W-1];
   assign nand_io_out = wdata;
   assign nand_io_oe  = we_busy;
   assign nand_ce_n   = cfg_q.ce_n;
   assign nand_cle    = cfg_q.cle;
   assign nand_ale    = cfg_q.ale;
   assign fan_en      = cfg_q.fan;
   assign led_n       = cfg_q.led_n;

   // ---------------- checks ----------------
   assert_we_drives_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_we_n |-> nand_io_oe);

   assert_read_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (re_busy || phase == PH_READ) |-> !nand_io_oe);

   assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n));

   assert_miso_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_READ) |-> !spi_miso);

   assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_CONFIG) |=> $stable(cfg_q));

   assert_ignore_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IGNORE && cs_act) |=> (phase == PH_IGNORE));
endmodule

// File: tb/tb_spi_nand_bridge.sv
`timescale 1ns/1ps
module tb_spi_nand_bridge;
   localparam int HALF = 8;
   localparam logic [7:0] CFG_VEC [6] = '{8'h3C, 8'hA5, 8'h00, 8'hFF, 8'h5A, 8'h81};

   logic clk = 1'b0, rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, mosi2 = 1'b0;
   logic miso, io_oe, ce_n, cle, ale, we_n, re_n, fan;
   logic [7:0] io_in, io_out;
   logic [3:0] led_n;

   int checks = 0, fails = 0;
   bit done = 1'b0, mon_on = 1'b0;
   int rd_idx = 0, re_cnt = 0, we_cnt = 0;
   logic [7:0] wlog [8];
   logic       woe  [8];
   logic       wcle [8];

   always #2 clk = ~clk;

   spi_nand_bridge dut (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
      .spi_mosi(mosi), .spi_mosi2(mosi2), .spi_miso(miso),
      .nand_io_in(io_in), .nand_io_out(io_out), .nand_io_oe(io_oe),
      .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale),
      .nand_we_n(we_n), .nand_re_n(re_n), .fan_en(fan), .led_n(led_n)
   );

   function automatic logic [7:0] nand_byte(input int i);
      return 8'(i * 71) ^ 8'h3C;
   endfunction

   assign io_in = nand_byte(rd_idx);

   always @(posedge re_n) if (mon_on) begin
      rd_idx++;
      re_cnt++;
   end

   always @(posedge we_n) if (mon_on) begin
      wlog[we_cnt % 8] = io_out;
      woe[we_cnt % 8]  = io_oe;
      wcle[we_cnt % 8] = cle;
      we_cnt++;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clk_bit(input logic a, input logic b, output logic so);
      @(negedge clk);
      mosi = a; mosi2 = b;
      repeat (HALF) @(negedge clk);
      so = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
   endtask

   task automatic xfer_single(input logic [7:0] txb, output logic [7:0] rxb);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(txb[i], 1'b0, b);
         rxb[i] = b;
      end
   endtask

   task automatic xfer_dual(input logic [7:0] txb);
      logic b;
      for (int k = 0; k < 4; k++) clk_bit(txb[7-2*k], txb[6-2*k], b);
   endtask

   task automatic cs_begin();
      @(negedge clk);
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic cs_end();
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (2 * HALF) @(negedge clk);
   endtask

   function automatic logic [7:0] outs();
      return {ce_n, cle, ale, fan, led_n};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] rx, orx;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      mon_on = 1'b1;

      // R1 reset state
      chk("R1 cfg", 32'(outs()), 32'h8F);
      chk("R1 we_n", 32'(we_n), 32'd1);
      chk("R1 re_n", 32'(re_n), 32'd1);
      chk("R1 io_oe", 32'(io_oe), 32'd0);
      chk("R1 miso", 32'(miso), 32'd0);

      // R2 table of config vectors; R11 MISO stays low meanwhile
      orx = '0;
      for (int v = 0; v < 6; v++) begin
         cs_begin();
         xfer_single(8'h09, rx); orx |= rx;
         xfer_single(CFG_VEC[v], rx); orx |= rx;
         cs_end();
         chk("R2 cfg vector", 32'(outs()), 32'(CFG_VEC[v]));
      end
      chk("R11 miso low in config", 32'(orx), 32'd0);
      chk("R2 no strobes from config", 32'(we_cnt + re_cnt), 32'd0);

      // R2 several config bytes in one transaction
      cs_begin();
      xfer_single(8'h09, rx);
      xfer_single(8'h11, rx);
      chk("R2 first of two", 32'(outs()), 32'h11);
      xfer_single(8'h22, rx);
      chk("R2 second of two", 32'(outs()), 32'h22);
      cs_end();

      // R3/R4 dual-line write, committed one byte late
      cs_begin();
      xfer_single(8'h09, rx); xfer_single(8'h4F, rx);
      cs_end();
      we_cnt = 0;
      cs_begin();
      xfer_single(8'h08, rx);
      xfer_dual(8'hA7);
      chk("R4 no commit before next byte", 32'(we_cnt), 32'd0);
      xfer_dual(8'h3C);
      chk("R4 first byte committed", 32'(we_cnt), 32'd1);
      chk("R3 dual pair order byte0", 32'(wlog[0]), 32'hA7);
      chk("R5 oe high at WE rise", 32'(woe[0]), 32'd1);
      chk("R2 CLE held during write", 32'(wcle[0]), 32'd1);
      xfer_dual(8'h00);
      chk("R4 last byte on trailing", 32'(we_cnt), 32'd2);
      chk("R3 dual byte1", 32'(wlog[1]), 32'h3C);
      cs_end();
      chk("R4 trailing discarded", 32'(we_cnt), 32'd2);
      chk("R5 bus released after write", 32'(io_oe), 32'd0);

      // R6/R8 read with one idle byte
      rd_idx = 0; re_cnt = 0;
      cs_begin();
      xfer_single(8'h0A, rx);
      chk("R6 no strobe after opcode", 32'(re_cnt), 32'd0);
      xfer_single(8'h00, rx);
      chk("R6 strobe after idle byte", 32'(re_cnt), 32'd1);
      for (int i = 0; i < 3; i++) begin
         xfer_single(8'h00, rx);
         chk("R6 read data", 32'(rx), 32'(nand_byte(i)));
         chk("R5 bus released in read", 32'(io_oe), 32'd0);
      end
      chk("R8 one strobe per boundary", 32'(re_cnt), 32'd4);
      cs_end();
      chk("R11 miso low after read", 32'(miso), 32'd0);

      // R7 fast read with four idle bytes
      rd_idx = 0; re_cnt = 0;
      cs_begin();
      xfer_single(8'h0B, rx);
      for (int i = 0; i < 3; i++) xfer_single(8'h00, rx);
      chk("R7 no strobe after three idle", 32'(re_cnt), 32'd0);
      xfer_single(8'h00, rx);
      chk("R7 strobe after fourth idle", 32'(re_cnt), 32'd1);
      xfer_single(8'h00, rx);
      chk("R7 fast data0", 32'(rx), 32'(nand_byte(0)));
      xfer_single(8'h00, rx);
      chk("R7 fast data1", 32'(rx), 32'(nand_byte(1)));
      cs_end();

      // R9 abort mid-byte in config
      cs_begin();
      xfer_single(8'h09, rx); xfer_single(8'h66, rx);
      cs_end();
      cs_begin();
      xfer_single(8'h09, rx);
      for (int i = 0; i < 4; i++) clk_bit(1'b0, 1'b0, rx[0]);
      cs_end();
      chk("R9 partial byte dropped", 32'(outs()), 32'h66);
      cs_begin();
      xfer_single(8'h09, rx); xfer_single(8'h12, rx);
      cs_end();
      chk("R9 parser back to opcode", 32'(outs()), 32'h12);

      // R9 abort discards pending write byte
      we_cnt = 0;
      cs_begin();
      xfer_single(8'h08, rx);
      xfer_dual(8'h55);
      cs_end();
      chk("R9 pending write dropped", 32'(we_cnt), 32'd0);

      // R10 unknown opcode ignored
      re_cnt = 0;
      cs_begin();
      xfer_single(8'h5E, rx);
      xfer_single(8'h09, rx);
      xfer_single(8'h00, rx);
      xfer_single(8'h0A, rx);
      cs_end();
      chk("R10 cfg unchanged", 32'(outs()), 32'h12);
      chk("R10 no strobes", 32'(we_cnt + re_cnt), 32'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule